// File: doc/BRIEF.md
# Audio Processor Control Register Slave

This block is the write-only control port of a stereo audio processor. It watches a two-wire I2C bus with the system clock, recognises start and stop conditions, and accepts transfers aimed at its own 7-bit module address. The first byte after the address selects a register. Each later byte in the same transfer is written to the selected register, and the selection then advances by one, so a host can load several settings in one burst.

Five 8-bit settings are held: left gain, right gain, low-frequency tone, high-frequency tone and a switch register. The switch register carries the mute, stereo-widening, mono/stereo and source-mode controls. The block presents every register as a parallel output, together with decoded mute, stereo-select and one-hot source-mode signals, for the analog control logic. The only drive the block puts on the bus is an open-drain acknowledge on the data line.

Top module: `audio_ctrl_i2c_slave`

## Requirements
- R1: A falling data line while the clock line stays high is a start; a rising data line while the clock line stays high is a stop. `bus_busy_o` goes high after a start and low after a stop.
- R2: A first byte whose upper 7 bits equal `DEV_ADDR` (default 7'b1000001) and whose bit 0 is 0 (write) is acknowledged. Every later byte of that transfer is also acknowledged, by pulling the data line low during the ninth clock.
- R3: A first byte with a different address or with bit 0 set to 1 (read) gets no acknowledge. The following bytes are then neither acknowledged nor written until the next start.
- R4: The register byte (second byte) selects a register: 0x00 left gain, 0x01 right gain, 0x02 low tone, 0x03 high tone, 0x08 switch. A data byte written there replaces that register whole and leaves the other registers unchanged.
- R5: After each data byte the stored register selection increments by one, so data bytes that follow a single register byte fill consecutive registers.
- R6: A register byte that selects no register is acknowledged, and its data bytes are acknowledged but discarded. Incrementing from 0x03 goes to 0x04, which selects nothing; it does not skip to 0x08.
- R7: Reset values are 0xC0 for both gains, 0xF0 for both tones and 0xFF for switch, so mute is active after reset. Mute stays active until a switch write clears bit 5.
- R8: The switch register decodes as follows: bit 5 mute (1 active) to `mute_o`, bit 4 to `spatial_o`, bit 3 to `stereo_o`, and bits 2:1 source mode. In the source mode, 11 asserts `mode_stereo_o`, 01 asserts `mode_a_o`, 10 asserts `mode_b_o`, and 00 asserts none. At most one of the three is high.
- R9: A register changes only after the acknowledge clock of a complete data byte. A stop in the middle of a byte leaves every register unchanged, and no register changes while the bus is idle.
- R10: A start arriving at any point, including mid-byte or after an ignored address, restarts reception with a fresh address byte.
- R11: `sda_oe_o` is high only during acknowledge clocks of a busy bus. It rises only while the clock line is low and is never high while the master clocks a data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe_o | output | 1 | Pull data line low (acknowledge) |
| vol_left_o | output | 8 | Left gain register |
| vol_right_o | output | 8 | Right gain register |
| bass_o | output | 8 | Low-frequency tone register |
| treble_o | output | 8 | High-frequency tone register |
| switch_o | output | 8 | Switch register |
| mute_o | output | 1 | Mute active |
| spatial_o | output | 1 | Stereo-widening select bit |
| stereo_o | output | 1 | Stereo/mono select bit |
| mode_stereo_o | output | 1 | Source mode: stereo |
| mode_a_o | output | 1 | Source mode: sound A |
| mode_b_o | output | 1 | Source mode: sound B |
| bus_busy_o | output | 1 | Between start and stop |

## Verification
Single-byte writes are applied through a table of register bytes and data values that covers every mapped register, unmapped selections and overwrites. Comparing the whole register bank after each write shows whether the right register, and only that one, changed. Multi-byte bursts check the increment, including the step from 0x03 into the unmapped 0x04. Wrong-address and read-bit transfers show that acknowledge and writes depend on the address byte. Stops and repeated starts placed mid-byte show that only complete, acknowledged data bytes commit. Switch values with each source-mode code and bit pattern show that the decode follows the bit positions.

// File: rtl/actl_pkg.sv
package actl_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 5;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    // register slots inside the bank
    localparam int SLOT_VOL_L  = 0;
    localparam int SLOT_VOL_R  = 1;
    localparam int SLOT_BASS   = 2;
    localparam int SLOT_TREBLE = 3;
    localparam int SLOT_SWITCH = 4;

    // switch register bit positions
    localparam int MUTE_BIT    = 5;
    localparam int SPATIAL_BIT = 4;
    localparam int STEREO_BIT  = 3;
    localparam int MODE_HI_BIT = 2;
    localparam int MODE_LO_BIT = 1;

    localparam logic [BYTE_W-1:0] VOL_RESET  = 8'hC0;
    localparam logic [BYTE_W-1:0] TONE_RESET = 8'hF0;
    localparam logic [BYTE_W-1:0] SW_RESET   = 8'hFF;

    typedef logic [NUM_REGS-1:0][BYTE_W-1:0] reg_bank_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_SKIP
    } rx_phase_e;

    typedef enum logic {
        KIND_SUB,
        KIND_DATA
    } byte_kind_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } sub_hit_t;

    // sparse register map: 0..3 contiguous, switch alone at 8
    function automatic sub_hit_t decode_sub(input logic [BYTE_W-1:0] sub);
        sub_hit_t r;
        r.hit = 1'b1;
        case (sub)
            8'h00:   r.idx = IDX_W'(SLOT_VOL_L);
            8'h01:   r.idx = IDX_W'(SLOT_VOL_R);
            8'h02:   r.idx = IDX_W'(SLOT_BASS);
            8'h03:   r.idx = IDX_W'(SLOT_TREBLE);
            8'h08:   r.idx = IDX_W'(SLOT_SWITCH);
            default: begin
                r.hit = 1'b0;
                r.idx = '0;
            end
        endcase
        return r;
    endfunction

    function automatic reg_bank_t reset_bank();
        reg_bank_t b;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (i == SLOT_SWITCH)
                b[i] = SW_RESET;
            else if (i == SLOT_VOL_L || i == SLOT_VOL_R)
                b[i] = VOL_RESET;
            else
                b[i] = TONE_RESET;
        end
        return b;
    endfunction

endpackage

// File: rtl/actl_line_sync.sv
module actl_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    // per line: STAGES synchroniser flops plus one history flop
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain_d;
        logic [STAGES:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], raw_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain_q <= '1;
            else
                chain_q <= chain_d;
        end

        assign level_o[g] = chain_q[STAGES-1];
        assign rise_o[g]  = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall_o[g]  = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

endmodule

// File: rtl/actl_byte_rx.sv
module actl_byte_rx
    import actl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_lvl_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              rx_valid_o,
    output byte_kind_e        rx_kind_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              sda_oe_o,
    output logic              busy_o
);

    typedef struct packed {
        rx_phase_e         phase;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-1:0] shift;
        logic              ack;
        logic              busy;
        logic              valid;
        byte_kind_e        kind;
        logic [BYTE_W-1:0] out_byte;
    } rx_state_t;

    rx_state_t s_d;
    rx_state_t s_q;

    logic addr_ok;
    logic receiving;

    assign addr_ok   = (s_q.shift[BYTE_W-1:1] == DEV_ADDR) && !s_q.shift[0];
    assign receiving = (s_q.phase == PH_ADDR) || (s_q.phase == PH_SUB) ||
                       (s_q.phase == PH_DATA);

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (start_i) begin
            s_d.phase   = PH_ADDR;
            s_d.bit_cnt = '0;
            s_d.ack     = 1'b0;
            s_d.busy    = 1'b1;
        end else if (stop_i) begin
            s_d.phase   = PH_IDLE;
            s_d.bit_cnt = '0;
            s_d.ack     = 1'b0;
            s_d.busy    = 1'b0;
        end else if (receiving) begin
            if (s_q.ack) begin
                // end of acknowledge clock: release line, hand byte over
                if (scl_fall_i) begin
                    s_d.ack      = 1'b0;
                    s_d.bit_cnt  = '0;
                    s_d.out_byte = s_q.shift;
                    s_d.valid    = (s_q.phase != PH_ADDR);
                    s_d.kind     = (s_q.phase == PH_SUB) ? KIND_SUB : KIND_DATA;
                    s_d.phase    = (s_q.phase == PH_ADDR) ? PH_SUB : PH_DATA;
                end
            end else if (s_q.bit_cnt == CNT_W'(BYTE_W)) begin
                // eighth bit finished: decide whether to acknowledge
                if (scl_fall_i) begin
                    if (s_q.phase == PH_ADDR && !addr_ok)
                        s_d.phase = PH_SKIP;
                    else
                        s_d.ack = 1'b1;
                end
            end else if (scl_rise_i) begin
                s_d.shift   = {s_q.shift[BYTE_W-2:0], sda_lvl_i};
                s_d.bit_cnt = s_q.bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase    <= PH_IDLE;
            s_q.bit_cnt  <= '0;
            s_q.shift    <= '0;
            s_q.ack      <= 1'b0;
            s_q.busy     <= 1'b0;
            s_q.valid    <= 1'b0;
            s_q.kind     <= KIND_SUB;
            s_q.out_byte <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_valid_o = s_q.valid;
    assign rx_kind_o  = s_q.kind;
    assign rx_byte_o  = s_q.out_byte;
    assign sda_oe_o   = s_q.ack;
    assign busy_o     = s_q.busy;

endmodule

// File: rtl/actl_reg_bank.sv
module actl_reg_bank
    import actl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid_i,
    input  byte_kind_e        rx_kind_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    output reg_bank_t         bank_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] sub;
        reg_bank_t         bank;
    } bank_state_t;

    bank_state_t s_d;
    bank_state_t s_q;
    sub_hit_t    sel;

    assign sel = decode_sub(s_q.sub);

    always_comb begin
        s_d = s_q;
        if (rx_valid_i) begin
            if (rx_kind_i == KIND_SUB) begin
                s_d.sub = rx_byte_i;
            end else begin
                if (sel.hit)
                    s_d.bank[sel.idx] = rx_byte_i;
                s_d.sub = s_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sub  <= '0;
            s_q.bank <= reset_bank();
        end else begin
            s_q <= s_d;
        end
    end

    assign bank_o = s_q.bank;

endmodule

// File: rtl/audio_ctrl_i2c_slave.sv
module audio_ctrl_i2c_slave
    import actl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1000001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [7:0] vol_left_o,
    output logic [7:0] vol_right_o,
    output logic [7:0] bass_o,
    output logic [7:0] treble_o,
    output logic [7:0] switch_o,
    output logic       mute_o,
    output logic       spatial_o,
    output logic       stereo_o,
    output logic       mode_stereo_o,
    output logic       mode_a_o,
    output logic       mode_b_o,
    output logic       bus_busy_o
);

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

    logic [1:0]        lvl;
    logic [1:0]        rise;
    logic [1:0]        fall;
    logic              scl_lvl;
    logic              start_det;
    logic              stop_det;
    logic              rx_valid;
    byte_kind_e        rx_kind;
    logic [BYTE_W-1:0] rx_byte;
    reg_bank_t         bank;

    actl_line_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({sda_i, scl_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign scl_lvl   = lvl[LINE_SCL];
    // data edge while the clock was high on both samples
    assign start_det = fall[LINE_SDA] & scl_lvl & ~rise[LINE_SCL];
    assign stop_det  = rise[LINE_SDA] & scl_lvl & ~rise[LINE_SCL];

    actl_byte_rx #(
        .DEV_ADDR (DEV_ADDR)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (rise[LINE_SCL]),
        .scl_fall_i (fall[LINE_SCL]),
        .sda_lvl_i  (lvl[LINE_SDA]),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .rx_valid_o (rx_valid),
        .rx_kind_o  (rx_kind),
        .rx_byte_o  (rx_byte),
        .sda_oe_o   (sda_oe_o),
        .busy_o     (bus_busy_o)
    );

    actl_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid_i (rx_valid),
        .rx_kind_i  (rx_kind),
        .rx_byte_i  (rx_byte),
        .bank_o     (bank)
    );

    assign vol_left_o  = bank[SLOT_VOL_L];
    assign vol_right_o = bank[SLOT_VOL_R];
    assign bass_o      = bank[SLOT_BASS];
    assign treble_o    = bank[SLOT_TREBLE];
    assign switch_o    = bank[SLOT_SWITCH];

    assign mute_o        = bank[SLOT_SWITCH][MUTE_BIT];
    assign spatial_o     = bank[SLOT_SWITCH][SPATIAL_BIT];
    assign stereo_o      = bank[SLOT_SWITCH][STEREO_BIT];
    assign mode_stereo_o =  bank[SLOT_SWITCH][MODE_HI_BIT] &  bank[SLOT_SWITCH][MODE_LO_BIT];
    assign mode_a_o      = ~bank[SLOT_SWITCH][MODE_HI_BIT] &  bank[SLOT_SWITCH][MODE_LO_BIT];
    assign mode_b_o      =  bank[SLOT_SWITCH][MODE_HI_BIT] & ~bank[SLOT_SWITCH][MODE_LO_BIT];

endmodule

// File: rtl/actl_slave_chk.sv
module actl_slave_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_lvl,
    input logic        start_det,
    input logic        stop_det,
    input logic        sda_oe,
    input logic        busy,
    input logic        mute,
    input logic        mode_st,
    input logic        mode_a,
    input logic        mode_b,
    input logic [39:0] bank_bits
);

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy);

    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy);

    // R11
    ack_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> busy);

    // R11
    ack_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R11
    ack_stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(bank_bits));

    // R8
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_st, mode_a, mode_b}));

    // R7
    mute_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> mute);

endmodule

bind audio_ctrl_i2c_slave actl_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .busy      (bus_busy_o),
    .mute      (mute_o),
    .mode_st   (mode_stereo_o),
    .mode_a    (mode_a_o),
    .mode_b    (mode_b_o),
    .bank_bits ({switch_o, treble_o, bass_o, vol_right_o, vol_left_o})
);

// File: tb/audio_ctrl_i2c_slave_bench.sv
module audio_ctrl_i2c_slave_bench;

    localparam logic [6:0] DEV = 7'b1000001;
    localparam int         Q   = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;

    logic       sda_oe;
    logic [7:0] vol_l, vol_r, bass, treble, sw;
    logic       mute, spatial, stereo, m_st, m_a, m_b, busy;

    wire sda_line = sda_m & ~sda_oe;

    audio_ctrl_i2c_slave #(.DEV_ADDR(DEV)) u_audio_ctrl_i2c_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sda_oe_o      (sda_oe),
        .vol_left_o    (vol_l),
        .vol_right_o   (vol_r),
        .bass_o        (bass),
        .treble_o      (treble),
        .switch_o      (sw),
        .mute_o        (mute),
        .spatial_o     (spatial),
        .stereo_o      (stereo),
        .mode_stereo_o (m_st),
        .mode_a_o      (m_a),
        .mode_b_o      (m_b),
        .bus_busy_o    (busy)
    );

    int checks   = 0;
    int failures = 0;
    int oe_bad   = 0;
    logic [2:0] acks;

    typedef struct packed {
        logic [7:0] sub;
        logic [7:0] data;
        logic [2:0] tgt;   // slot 0..4, 7 = no register
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'hC5, 3'd0},
        '{8'h01, 8'hE3, 3'd1},
        '{8'h02, 8'hF9, 3'd2},
        '{8'h03, 8'hF4, 3'd3},
        '{8'h08, 8'hFB, 3'd4},
        '{8'h05, 8'h77, 3'd7},
        '{8'h00, 8'hFF, 3'd0},
        '{8'h03, 8'hF0, 3'd3},
        '{8'h09, 8'h12, 3'd7},
        '{8'h01, 8'hC0, 3'd1},
        '{8'h02, 8'hF0, 3'd2}
    };

    function automatic logic [39:0] bank_now();
        return {sw, treble, bass, vol_r, vol_l};
    endfunction

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(Q);
        if (sda_oe) oe_bad++;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic write1(input logic [7:0] sub, input logic [7:0] data);
        i2c_start();
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(sub, acks[1]);
        send_byte(data, acks[0]);
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [39:0] exp;
        logic [39:0] snap;
        logic        a;

        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R7 reset values, mute active; R8 reset decode
        chk("R7 reset bank", bank_now(), 40'hFF_F0_F0_C0_C0);
        chk("R7 reset mute", mute, 1);
        chk("R8 reset mode stereo", {m_st, m_a, m_b}, 3'b100);
        chk("R11 reset oe", sda_oe, 0);
        chk("R1 reset idle", busy, 0);

        // R1 busy between start and stop
        i2c_start();
        chk("R1 busy after start", busy, 1);
        i2c_stop();
        chk("R1 idle after stop", busy, 0);

        // R4 R2 table of single writes
        for (int v = 0; v < NV; v++) begin
            exp = bank_now();
            if (VECS[v].tgt != 3'd7)
                exp[VECS[v].tgt * 8 +: 8] = VECS[v].data;
            write1(VECS[v].sub, VECS[v].data);
            chk("R2 acks on write", acks, 3'b111);
            chk((VECS[v].tgt == 3'd7) ? "R6 unmapped discarded" : "R4 register write",
                bank_now(), exp);
        end

        // R3 wrong address: no ack, data ignored
        snap = bank_now();
        i2c_start();
        send_byte({7'h22, 1'b0}, a);
        chk("R3 wrong address no ack", a, 0);
        send_byte(8'h00, a);
        chk("R3 later byte no ack", a, 0);
        send_byte(8'h55, a);
        i2c_stop();
        chk("R3 bank unchanged after mismatch", bank_now(), snap);

        // R3 read bit: no ack
        i2c_start();
        send_byte({DEV, 1'b1}, a);
        chk("R3 read request no ack", a, 0);
        // R10 restart after ignored address
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        chk("R10 restart address ack", a, 1);
        send_byte(8'h02, a);
        send_byte(8'hF6, a);
        i2c_stop();
        chk("R10 write after restart", bass, 8'hF6);

        // R5 burst from 0, R6 continues to 0x04 (discarded)
        snap = bank_now();
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'hC1, a);
        send_byte(8'hC2, a);
        send_byte(8'hF3, a);
        send_byte(8'hF4, a);
        send_byte(8'hD9, a);
        chk("R6 data to 0x04 acked", a, 1);
        i2c_stop();
        chk("R5 burst fills 0..3", bank_now(), {snap[39:32], 32'hF4_F3_C2_C1});
        chk("R6 switch untouched by 0x04", sw, snap[39:32]);

        // R7 R8 switch decode
        write1(8'h08, 8'hDF);
        chk("R7 mute cleared", mute, 0);
        chk("R8 mode 11 stereo", {m_st, m_a, m_b}, 3'b100);
        chk("R8 select bits", {spatial, stereo}, 2'b11);
        write1(8'h08, 8'hDB);
        chk("R8 mode 01 sound A", {m_st, m_a, m_b}, 3'b010);
        write1(8'h08, 8'hDD);
        chk("R8 mode 10 sound B", {m_st, m_a, m_b}, 3'b001);
        write1(8'h08, 8'hD9);
        chk("R8 mode 00 none", {m_st, m_a, m_b}, 3'b000);
        write1(8'h08, 8'hE7);
        chk("R8 mute and select bits", {mute, spatial, stereo}, 3'b100);

        // R9 stop mid-byte leaves registers unchanged
        snap = bank_now();
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        i2c_stop();
        chk("R9 partial byte discarded", bank_now(), snap);

        // R10 start mid-byte restarts reception
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h01, a);
        for (int k = 0; k < 5; k++) send_bit(1'b0);
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        chk("R10 ack after mid-byte start", a, 1);
        send_byte(8'h02, a);
        send_byte(8'hF7, a);
        i2c_stop();
        chk("R10 new transfer applied", bank_now(),
            {snap[39:24], 8'hF7, snap[15:0]});

        // R11 no drive while master clocks data bits
        chk("R11 no oe on data bits", oe_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule